// File: doc/BRIEF.md
# I2C Controller Configuration Register

This block is the software-visible configuration word of an I2C controller. It sits on an APB-style bus at one offset and holds the settings that the protocol engine reads as plain wires. These settings are the master enable, the bus speed class, the 7/10-bit address widths for the slave and master roles, permission to issue repeated starts, the slave disable, and a set of bits that shape interrupts and bus holding.

Each field's reset value is an elaboration parameter. Several fields are optional. When its feature parameter is off, an optional field is read-only and reads as zero. The master 10-bit flag can instead be a live copy of a flag held in the target-address register, which comes in on a port. Software can change the word only while the controller is disabled; a write at any other time is dropped. An illegal speed code is replaced in hardware by the highest speed the build supports.

Top module: `i2c_ctrl_cfg_reg`

## Requirements
- R1: After reset, every field holds its parameterised reset value: speed holds SPEED_MAX and every optional field reads 0. With default parameters the read value is 0x0000007D.
- R2: A write to the register offset while `ctrl_enable` is 1 leaves every stored field unchanged.
- R3: A written speed code (bits [2:1]) of 0, or one greater than SPEED_MAX, stores SPEED_MAX.
- R4: A written speed code from 1 to SPEED_MAX (1 standard, 2 fast/fast-plus, 3 high speed) is stored unchanged.
- R5: With DYN_TAR=1, bit 4 always reads `tgt_10bit` and ignores writes. With DYN_TAR=0, it is an ordinary read/write bit.
- R6: These bits are writable only when their parameter is 1 and otherwise read 0 and ignore writes: bit 9 (HAS_RX_HOLD), bit 10 (HAS_STOP_MA), bit 11 (HAS_BUS_CLEAR), bit 16 (HAS_OPT_SAR), bit 17 (HAS_SMBUS), bits 18 and 19 (HAS_SMB_ARP). Bits 0, 3, 5, 6, 7 and 8 are always writable.
- R7: Bits 31:20 and 15:12 always read 0.
- R8: `pready` is always 1 and `pslverr` always 0. Read data appears in the same cycle the read is presented.
- R9: The cfg_* output ports equal the register bits: 0 master enable, [2:1] speed, 3 slave 10-bit, 4 master 10-bit, 5 restart enable, 6 slave disable, 7 stop-only-if-addressed, 8 TX-empty control, 9 RX-full hold, 10 stop-only-if-master-active, 11 bus clear, 16 optional slave address, 17 quick command, 18 address resolution, 19 persistent slave address.
- R10: An access to any offset other than REG_OFFSET reads 0 and changes no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 write, 0 read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, zero when not selected |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| ctrl_enable | input | 1 | Controller enable; 1 locks the register |
| tgt_10bit | input | 1 | 10-bit flag from the target address register |
| cfg_master_en | output | 1 | Master enable |
| cfg_speed | output | 2 | Speed class |
| cfg_slv_10bit | output | 1 | Slave responds to 10-bit addresses |
| cfg_mst_10bit | output | 1 | Master uses 10-bit addressing |
| cfg_restart_en | output | 1 | Repeated start allowed |
| cfg_slave_dis | output | 1 | Slave role disabled |
| cfg_stop_if_addr | output | 1 | Stop interrupt only if addressed |
| cfg_txe_ctrl | output | 1 | TX-empty interrupt control |
| cfg_rx_hold | output | 1 | Hold bus when RX store full |
| cfg_stop_if_mst_act | output | 1 | Stop interrupt only if master active |
| cfg_bus_clear_en | output | 1 | Bus clear feature enable |
| cfg_opt_sar_en | output | 1 | Optional slave address enable |
| cfg_smb_quick_en | output | 1 | Quick-command slave enable |
| cfg_smb_arp_en | output | 1 | Address resolution enable |
| cfg_smb_persist_en | output | 1 | Persistent slave address enable |

## Verification
The bench builds two copies side by side. The first enables every optional feature, uses a local master 10-bit bit and sets SPEED_MAX=2, so codes 0 and 3 both exercise speed legalisation. The second disables every optional feature, mirrors the target flag, sets SPEED_MAX=3 and inverts most reset values, which exercises the read-only zero paths, the live bit-4 copy and the parameterised resets. Many pseudo-random write words are compared against an arithmetic model of both builds, and explicit sweeps cover all four speed codes, locked writes and foreign offsets.

// File: rtl/i2c_cfg_pkg.sv
// Shared bit positions and helpers for the I2C configuration register.
// Assumes a single 32-bit register word; positions are fixed because the
// protocol engine and software decode them.
package i2c_cfg_pkg;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned FIELD_TOP  = 20;   // bits at and above are reserved
    localparam int unsigned POS_MST_EN = 0;
    localparam int unsigned POS_SPD_LO = 1;
    localparam int unsigned POS_SPD_HI = 2;
    localparam int unsigned POS_SLV10  = 3;
    localparam int unsigned POS_MST10  = 4;
    localparam int unsigned POS_RSTRT  = 5;
    localparam int unsigned POS_SLVDIS = 6;
    localparam int unsigned POS_STPADR = 7;
    localparam int unsigned POS_TXE    = 8;
    localparam int unsigned POS_RXHOLD = 9;
    localparam int unsigned POS_STPMA  = 10;
    localparam int unsigned POS_BUSCLR = 11;
    localparam int unsigned POS_OSAR   = 16;
    localparam int unsigned POS_QUICK  = 17;
    localparam int unsigned POS_ARP    = 18;
    localparam int unsigned POS_PERSIS = 19;

    // Replace an out-of-range speed code by the build's maximum.
    function automatic logic [1:0] legal_speed(input logic [1:0] code,
                                               input logic [1:0] max_code);
        if (code == 2'd0 || code > max_code) return max_code;
        return code;
    endfunction
endpackage

// File: rtl/i2c_cfg_apb_port.sv
// Bus-side decode for the configuration register.
// Assumes zero-wait-state APB: a write commits on the access-phase edge.
// Writes are suppressed while the controller enable is set.
module i2c_cfg_apb_port #(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned REG_OFFSET = 0
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic              ctrl_enable,
    output logic              wr_en,
    output logic              rd_hit
);
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_OFFSET);

    logic addr_hit;

    // Offset match, write commit and read select.
    always_comb begin
        addr_hit = (paddr == OFS);
        wr_en    = psel && penable && pwrite && addr_hit && !ctrl_enable;
        rd_hit   = psel && !pwrite && addr_hit;
    end
endmodule

// File: rtl/i2c_cfg_flag.sv
// One single-bit configuration field.
// When WRITABLE is 0 the field is read-only and reads 0; its inputs are ignored.
module i2c_cfg_flag #(
    parameter bit WRITABLE = 1'b1,
    parameter bit RST_VAL  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic d,
    output logic q
);
    generate
        if (WRITABLE) begin : g_rw
            // Hold the field; load on an accepted write.
            always_ff @(posedge clk) begin
                if (!rst_n)     q <= RST_VAL;
                else if (wr_en) q <= d;
            end
        end else begin : g_ro
            logic unused_flag;
            assign unused_flag = ^{clk, rst_n, wr_en, d};
            assign q = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/i2c_cfg_speed.sv
// Speed-class field with hardware legalisation.
// Assumes 1 <= SPEED_MAX <= 3; reset and illegal codes both give SPEED_MAX.
module i2c_cfg_speed #(
    parameter int unsigned SPEED_MAX = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_code,
    output logic [1:0] q
);
    import i2c_cfg_pkg::*;

    localparam logic [1:0] MAX_CODE = 2'(SPEED_MAX);

    logic [1:0] code_ok;

    // Legalise the incoming code.
    always_comb code_ok = legal_speed(wr_code, MAX_CODE);

    // Hold the speed class.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= MAX_CODE;
        else if (wr_en) q <= code_ok;
    end
endmodule

// File: rtl/i2c_ctrl_cfg_reg.sv
// Configuration register of an I2C controller, top level.
// Assumes one 32-bit register at REG_OFFSET on a zero-wait APB port.
// Optional fields are read-only zero when their feature parameter is 0;
// bit 4 can mirror the target register's 10-bit flag (DYN_TAR=1).
module i2c_ctrl_cfg_reg #(
    parameter int unsigned ADDR_W        = 8,
    parameter int unsigned REG_OFFSET    = 0,
    parameter int unsigned SPEED_MAX     = 2,
    parameter bit          MST_EN_RST    = 1'b1,
    parameter bit          SLV10_RST     = 1'b1,
    parameter bit          MST10_RST     = 1'b1,
    parameter bit          RESTART_RST   = 1'b1,
    parameter bit          SLV_DIS_RST   = 1'b1,
    parameter bit          STOP_ADDR_RST = 1'b0,
    parameter bit          TXE_RST       = 1'b0,
    parameter bit          DYN_TAR       = 1'b0,
    parameter bit          HAS_RX_HOLD   = 1'b0,
    parameter bit          HAS_STOP_MA   = 1'b0,
    parameter bit          HAS_BUS_CLEAR = 1'b0,
    parameter bit          HAS_OPT_SAR   = 1'b0,
    parameter bit          HAS_SMBUS     = 1'b0,
    parameter bit          HAS_SMB_ARP   = 1'b0
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              ctrl_enable,
    input  logic              tgt_10bit,
    output logic              cfg_master_en,
    output logic [1:0]        cfg_speed,
    output logic              cfg_slv_10bit,
    output logic              cfg_mst_10bit,
    output logic              cfg_restart_en,
    output logic              cfg_slave_dis,
    output logic              cfg_stop_if_addr,
    output logic              cfg_txe_ctrl,
    output logic              cfg_rx_hold,
    output logic              cfg_stop_if_mst_act,
    output logic              cfg_bus_clear_en,
    output logic              cfg_opt_sar_en,
    output logic              cfg_smb_quick_en,
    output logic              cfg_smb_arp_en,
    output logic              cfg_smb_persist_en
);
    import i2c_cfg_pkg::*;

    // Per-bit writability and reset value, derived from the parameters.
    localparam logic [FIELD_TOP-1:0] WR_MASK =
        (FIELD_TOP'(1) << POS_MST_EN) |
        (FIELD_TOP'(1) << POS_SLV10)  |
        (FIELD_TOP'(!DYN_TAR) << POS_MST10) |
        (FIELD_TOP'(1) << POS_RSTRT)  |
        (FIELD_TOP'(1) << POS_SLVDIS) |
        (FIELD_TOP'(1) << POS_STPADR) |
        (FIELD_TOP'(1) << POS_TXE)    |
        (FIELD_TOP'(HAS_RX_HOLD)   << POS_RXHOLD) |
        (FIELD_TOP'(HAS_STOP_MA)   << POS_STPMA)  |
        (FIELD_TOP'(HAS_BUS_CLEAR) << POS_BUSCLR) |
        (FIELD_TOP'(HAS_OPT_SAR)   << POS_OSAR)   |
        (FIELD_TOP'(HAS_SMBUS)     << POS_QUICK)  |
        (FIELD_TOP'(HAS_SMB_ARP)   << POS_ARP)    |
        (FIELD_TOP'(HAS_SMB_ARP)   << POS_PERSIS);

    localparam logic [FIELD_TOP-1:0] RST_VEC =
        (FIELD_TOP'(MST_EN_RST)    << POS_MST_EN) |
        (FIELD_TOP'(SLV10_RST)     << POS_SLV10)  |
        (FIELD_TOP'(MST10_RST)     << POS_MST10)  |
        (FIELD_TOP'(RESTART_RST)   << POS_RSTRT)  |
        (FIELD_TOP'(SLV_DIS_RST)   << POS_SLVDIS) |
        (FIELD_TOP'(STOP_ADDR_RST) << POS_STPADR) |
        (FIELD_TOP'(TXE_RST)       << POS_TXE);

    logic                 wr_en;
    logic                 rd_hit;
    logic [FIELD_TOP-1:0] fld_q;
    logic [1:0]           speed_q;
    logic                 unused_hi;

    assign unused_hi = ^pwdata[WORD_W-1:FIELD_TOP];

    i2c_cfg_apb_port #(
        .ADDR_W     (ADDR_W),
        .REG_OFFSET (REG_OFFSET)
    ) u_port (
        .psel        (psel),
        .penable     (penable),
        .pwrite      (pwrite),
        .paddr       (paddr),
        .ctrl_enable (ctrl_enable),
        .wr_en       (wr_en),
        .rd_hit      (rd_hit)
    );

    i2c_cfg_speed #(
        .SPEED_MAX (SPEED_MAX)
    ) u_speed (
        .clk     (pclk),
        .rst_n   (presetn),
        .wr_en   (wr_en),
        .wr_code (pwdata[POS_SPD_HI:POS_SPD_LO]),
        .q       (speed_q)
    );

    // One storage cell per single-bit position; speed bits come from u_speed.
    generate
        for (genvar i = 0; i < FIELD_TOP; i++) begin : g_bit
            if (i == POS_SPD_LO) begin : g_spd_lo
                assign fld_q[i] = speed_q[0];
            end else if (i == POS_SPD_HI) begin : g_spd_hi
                assign fld_q[i] = speed_q[1];
            end else if (i == POS_MST10 && DYN_TAR) begin : g_mirror
                logic unused_wd;
                assign unused_wd = pwdata[i];
                assign fld_q[i]  = tgt_10bit;
            end else begin : g_cell
                i2c_cfg_flag #(
                    .WRITABLE (WR_MASK[i]),
                    .RST_VAL  (RST_VEC[i])
                ) u_flag (
                    .clk   (pclk),
                    .rst_n (presetn),
                    .wr_en (wr_en),
                    .d     (pwdata[i]),
                    .q     (fld_q[i])
                );
            end
        end
        if (!DYN_TAR) begin : g_no_mirror
            logic unused_tgt;
            assign unused_tgt = tgt_10bit;
        end
    endgenerate

    // Read data and fixed bus response.
    always_comb begin
        prdata  = rd_hit ? {{(WORD_W-FIELD_TOP){1'b0}}, fld_q} : '0;
        pready  = 1'b1;
        pslverr = 1'b0;
    end

    // Decoded field outputs for the protocol engine.
    always_comb begin
        cfg_master_en       = fld_q[POS_MST_EN];
        cfg_speed           = fld_q[POS_SPD_HI:POS_SPD_LO];
        cfg_slv_10bit       = fld_q[POS_SLV10];
        cfg_mst_10bit       = fld_q[POS_MST10];
        cfg_restart_en      = fld_q[POS_RSTRT];
        cfg_slave_dis       = fld_q[POS_SLVDIS];
        cfg_stop_if_addr    = fld_q[POS_STPADR];
        cfg_txe_ctrl        = fld_q[POS_TXE];
        cfg_rx_hold         = fld_q[POS_RXHOLD];
        cfg_stop_if_mst_act = fld_q[POS_STPMA];
        cfg_bus_clear_en    = fld_q[POS_BUSCLR];
        cfg_opt_sar_en      = fld_q[POS_OSAR];
        cfg_smb_quick_en    = fld_q[POS_QUICK];
        cfg_smb_arp_en      = fld_q[POS_ARP];
        cfg_smb_persist_en  = fld_q[POS_PERSIS];
    end
endmodule

// File: rtl/i2c_ctrl_cfg_chk.sv
// Property checker for i2c_ctrl_cfg_reg, attached by bind.
// Assumes the same parameter values as the bound instance.
module i2c_ctrl_cfg_chk #(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned REG_OFFSET  = 0,
    parameter int unsigned SPEED_MAX   = 2,
    parameter bit          DYN_TAR     = 1'b0,
    parameter bit          HAS_RX_HOLD = 1'b0,
    parameter bit          HAS_STOP_MA = 1'b0
) (
    input logic              pclk,
    input logic              presetn,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [31:0]       prdata,
    input logic              pready,
    input logic              pslverr,
    input logic              ctrl_enable,
    input logic              tgt_10bit,
    input logic [1:0]        cfg_speed,
    input logic              cfg_master_en,
    input logic              cfg_slave_dis,
    input logic              cfg_rx_hold,
    input logic              cfg_stop_if_mst_act
);
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_OFFSET);

    logic locked_wr;
    logic rd_here;
    logic rd_else;
    assign locked_wr = psel && penable && pwrite && ctrl_enable;
    assign rd_here   = psel && !pwrite && (paddr == OFS);
    assign rd_else   = psel && !pwrite && (paddr != OFS);

    // R3
    speed_range_chk: assert property (@(posedge pclk) disable iff (!presetn)
        cfg_speed != 2'd0 && cfg_speed <= 2'(SPEED_MAX));

    // R2
    locked_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
        locked_wr |=> $stable(cfg_speed) && $stable(cfg_master_en) && $stable(cfg_slave_dis));

    // R7
    reserved_zero_chk: assert property (@(posedge pclk) disable iff (!presetn)
        prdata[31:20] == 12'd0 && prdata[15:12] == 4'd0);

    // R8
    bus_resp_chk: assert property (@(posedge pclk) disable iff (!presetn)
        pready && !pslverr);

    // R5
    mirror_read_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (rd_here && DYN_TAR) |-> prdata[4] == tgt_10bit);

    // R6
    ro_zero_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (!HAS_RX_HOLD |-> !cfg_rx_hold) and (!HAS_STOP_MA |-> !cfg_stop_if_mst_act));

    // R10
    foreign_read_chk: assert property (@(posedge pclk) disable iff (!presetn)
        rd_else |-> prdata == 32'd0);
endmodule

bind i2c_ctrl_cfg_reg i2c_ctrl_cfg_chk #(
    .ADDR_W      (ADDR_W),
    .REG_OFFSET  (REG_OFFSET),
    .SPEED_MAX   (SPEED_MAX),
    .DYN_TAR     (DYN_TAR),
    .HAS_RX_HOLD (HAS_RX_HOLD),
    .HAS_STOP_MA (HAS_STOP_MA)
) u_chk (
    .pclk                (pclk),
    .presetn             (presetn),
    .psel                (psel),
    .penable             (penable),
    .pwrite              (pwrite),
    .paddr               (paddr),
    .prdata              (prdata),
    .pready              (pready),
    .pslverr             (pslverr),
    .ctrl_enable         (ctrl_enable),
    .tgt_10bit           (tgt_10bit),
    .cfg_speed           (cfg_speed),
    .cfg_master_en       (cfg_master_en),
    .cfg_slave_dis       (cfg_slave_dis),
    .cfg_rx_hold         (cfg_rx_hold),
    .cfg_stop_if_mst_act (cfg_stop_if_mst_act)
);

// File: tb/i2c_ctrl_cfg_reg_tb.sv
`timescale 1ns/1ps
// Bench: two builds of the register on one bus, checked against a bench model.
module i2c_ctrl_cfg_reg_tb;
    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = 8'd0;
    logic [31:0] pwdata = 32'd0;
    logic        ctrl_enable = 1'b0;
    logic        tgt_10bit = 1'b0;

    logic [31:0] rd_a, rd_b;
    logic        rdy_a, rdy_b, err_a, err_b;
    logic [1:0]  spd_a, spd_b;
    logic [14:0] f_a, f_b;   // single-bit field outputs, see port vectors below

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 pclk = ~pclk;

    // Build A: every option on, local bit 4, SPEED_MAX=2, default resets.
    i2c_ctrl_cfg_reg #(
        .SPEED_MAX(2), .HAS_RX_HOLD(1), .HAS_STOP_MA(1), .HAS_BUS_CLEAR(1),
        .HAS_OPT_SAR(1), .HAS_SMBUS(1), .HAS_SMB_ARP(1)
    ) u_dut (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(rd_a),
        .pready(rdy_a), .pslverr(err_a), .ctrl_enable(ctrl_enable),
        .tgt_10bit(tgt_10bit), .cfg_master_en(f_a[0]), .cfg_speed(spd_a),
        .cfg_slv_10bit(f_a[1]), .cfg_mst_10bit(f_a[2]), .cfg_restart_en(f_a[3]),
        .cfg_slave_dis(f_a[4]), .cfg_stop_if_addr(f_a[5]), .cfg_txe_ctrl(f_a[6]),
        .cfg_rx_hold(f_a[7]), .cfg_stop_if_mst_act(f_a[8]), .cfg_bus_clear_en(f_a[9]),
        .cfg_opt_sar_en(f_a[10]), .cfg_smb_quick_en(f_a[11]), .cfg_smb_arp_en(f_a[12]),
        .cfg_smb_persist_en(f_a[13])
    );

    // Build B: every option off, bit 4 mirrors tgt_10bit, SPEED_MAX=3, other resets.
    i2c_ctrl_cfg_reg #(
        .SPEED_MAX(3), .MST_EN_RST(0), .SLV10_RST(0), .RESTART_RST(0),
        .SLV_DIS_RST(0), .STOP_ADDR_RST(1), .TXE_RST(1), .DYN_TAR(1)
    ) u_dut_alt (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(rd_b),
        .pready(rdy_b), .pslverr(err_b), .ctrl_enable(ctrl_enable),
        .tgt_10bit(tgt_10bit), .cfg_master_en(f_b[0]), .cfg_speed(spd_b),
        .cfg_slv_10bit(f_b[1]), .cfg_mst_10bit(f_b[2]), .cfg_restart_en(f_b[3]),
        .cfg_slave_dis(f_b[4]), .cfg_stop_if_addr(f_b[5]), .cfg_txe_ctrl(f_b[6]),
        .cfg_rx_hold(f_b[7]), .cfg_stop_if_mst_act(f_b[8]), .cfg_bus_clear_en(f_b[9]),
        .cfg_opt_sar_en(f_b[10]), .cfg_smb_quick_en(f_b[11]), .cfg_smb_arp_en(f_b[12]),
        .cfg_smb_persist_en(f_b[13])
    );
    assign f_a[14] = 1'b0;
    assign f_b[14] = 1'b0;

    // Port outputs reassembled into register bit positions (R9 map).
    function automatic logic [31:0] port_vec(input logic [14:0] f, input logic [1:0] s);
        return {12'd0, f[13], f[12], f[11], f[10], 4'd0, f[9], f[8], f[7], f[6],
                f[5], f[4], f[3], f[2], f[1], s, f[0]};
    endfunction

    // Bench model of a write: masked merge, then speed legalisation.
    function automatic logic [31:0] model_wr(input logic [31:0] old, input logic [31:0] w,
                                             input logic [31:0] mask, input int smax);
        logic [31:0] n;
        int sp;
        n  = (old & ~mask) | (w & mask);
        sp = int'(w[2:1]);
        if (sp == 0 || sp > smax) sp = smax;
        n[2:1] = 2'(sp);
        return n;
    endfunction

    localparam logic [31:0] MASK_A = 32'h000F_0FF9;
    localparam logic [31:0] MASK_B = 32'h0000_01E9;
    logic [31:0] exp_a = 32'h0000_007D;
    logic [31:0] exp_b = 32'h0000_0186;   // bit 4 added from tgt_10bit when read

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge pclk); psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge pclk); penable = 1'b1;
        @(negedge pclk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [7:0] a, output logic [31:0] ra, output logic [31:0] rb);
        @(negedge pclk); psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge pclk); penable = 1'b1;
        #1;
        ra = rd_a; rb = rd_b;
        // R8: zero-wait response, no error
        check("R8", {30'd0, rdy_a & rdy_b, err_a | err_b}, 32'd2);
        @(negedge pclk); psel = 1'b0; penable = 1'b0;
    endtask

    // Read both builds at offset 0 and compare against the model.
    task automatic check_both(input string req);
        logic [31:0] ra, rb, eb;
        apb_rd(8'h00, ra, rb);
        eb = exp_b | (32'(tgt_10bit) << 4);
        check(req, ra, exp_a);
        check(req, rb, eb);
        // R7: reserved bits read zero
        check("R7", (ra | rb) & 32'hFFF0_F000, 32'd0);
        // R9: field ports match the register
        check("R9", port_vec(f_a, spd_a), exp_a);
        check("R9", port_vec(f_b, spd_b), eb);
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        logic [31:0] seed;
        logic [31:0] w;
        logic [31:0] ra, rb;
        repeat (4) @(negedge pclk);
        presetn = 1'b1;

        // R1: parameterised reset values of both builds
        check_both("R1");

        // R3 / R4: every speed code, other bits cleared
        for (int sp = 0; sp < 4; sp++) begin
            w = 32'(sp) << 1;
            apb_wr(8'h00, w);
            exp_a = model_wr(exp_a, w, MASK_A, 2);
            exp_b = model_wr(exp_b, w, MASK_B, 3);
            check((sp == 0 || sp == 3) ? "R3" : "R4", {30'd0, spd_a}, {30'd0, exp_a[2:1]});
            check((sp == 0) ? "R3" : "R4", {30'd0, spd_b}, {30'd0, exp_b[2:1]});
        end

        // R6: all-ones word reaches only the writable bits of each build
        apb_wr(8'h00, 32'hFFFF_FFFF);
        exp_a = model_wr(exp_a, 32'hFFFF_FFFF, MASK_A, 2);
        exp_b = model_wr(exp_b, 32'hFFFF_FFFF, MASK_B, 3);
        check_both("R6");

        // R6 / R5 / R3: pseudo-random words against the model
        seed = 32'h1234_5678;
        for (int i = 0; i < 160; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            w = seed;
            if (i % 16 == 0) tgt_10bit = ~tgt_10bit;
            apb_wr(8'h00, w);
            exp_a = model_wr(exp_a, w, MASK_A, 2);
            exp_b = model_wr(exp_b, w, MASK_B, 3);
            check_both("R6");
        end

        // R5: bit 4 of build B follows tgt_10bit and ignores writes
        tgt_10bit = 1'b0;
        apb_wr(8'h00, 32'h0000_0010);
        exp_a = model_wr(exp_a, 32'h0000_0010, MASK_A, 2);
        exp_b = model_wr(exp_b, 32'h0000_0010, MASK_B, 3);
        apb_rd(8'h00, ra, rb);
        check("R5", {31'd0, rb[4]}, 32'd0);
        check("R5", {31'd0, ra[4]}, 32'd1);
        tgt_10bit = 1'b1;
        apb_rd(8'h00, ra, rb);
        check("R5", {31'd0, rb[4]}, 32'd1);

        // R2: writes while the controller is enabled are dropped
        ctrl_enable = 1'b1;
        apb_wr(8'h00, ~exp_a);
        apb_wr(8'h00, 32'h0000_0000);
        check_both("R2");
        tgt_10bit = 1'b0;
        check_both("R5");
        ctrl_enable = 1'b0;

        // R10: other offsets read zero and write nothing
        apb_wr(8'h04, ~exp_a);
        apb_rd(8'h04, ra, rb);
        check("R10", ra | rb, 32'd0);
        check_both("R10");

        done = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge pclk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            finish_run();
        end
    end
endmodule